// File: doc/BRIEF.md
# Prescaled Interval Timer and Event Counter

This block pairs a free-running 6-bit prescaler with a 4-bit up-counter. The clock input is the instruction-cycle clock. The prescaler advances on every cycle. Only the halt input can stop it, and the prescaler keeps its phase across a halt. Each time the prescaler wraps, it emits a one-cycle pulse. In timer mode, the counter steps on each of these pulses. In event mode, it steps on each qualified rising edge of an external pin. That pin passes through a two-flop synchroniser and a level filter, which accept a level only after it has held for two cycles.

Software writes a 4-bit start value. The block keeps that value as the reload base. When the counter steps out of its all-ones state, it reloads the base and raises a sticky flag. The flag is the timer interrupt request. Because of the reload, a start value `p` gives a repeating interval of (16 − p) × 64 cycles in timer mode with no further software action. A clear request drops the flag. An overflow in the same cycle keeps it set.

Top module: `prescaled_timer`

## Requirements
- R1: `pre_ovf` is high for exactly one cycle in every 64 cycles while `halt` is low. Its timing is not affected by `load`, `mode` or the counter state.
- R2: While `halt` is high, the prescaler holds its value, `pre_ovf` stays low and `count` does not step. When `halt` falls, the prescaler resumes from the phase it held, so a halt of H cycles stretches one prescaler period to 64 + H.
- R3: A cycle with `load` high puts `preset` into both `count` and the reload base at the next edge. `load` wins over a counter step in the same cycle.
- R4: In timer mode (`mode` = 0), `count` steps by one on each `pre_ovf` pulse. Successive overflows are then (16 − p) × 64 cycles apart, for example 64 cycles for p = 15, 384 cycles for p = 10 and 1024 cycles for p = 0.
- R5: A step taken while `count` is 15 reloads `count` with the stored base and sets `flag` at the same edge. This holds in both modes.
- R6: `flag_clr` clears `flag` at the next edge. When an overflow occurs in the same cycle, `flag` stays set.
- R7: In event mode (`mode` = 1), `count` steps once for each rise of `ext_pin` that is held high for at least 2 cycles after being low for at least 2 cycles. The step lands no more than 4 cycles after the rise. Prescaler pulses do not step the counter in this mode.
- R8: In event mode, a high level shorter than 2 cycles is not counted. A low gap shorter than 2 cycles does not end the high level, so the two high stretches on either side of it count as one event.
- R9: After reset, `count` = 0, `flag` = 0 and the prescaler is at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| halt | input | 1 | Freezes the prescaler and the counter while high |
| mode | input | 1 | 0 = count prescaler pulses, 1 = count external events |
| load | input | 1 | One-cycle strobe that writes `preset` into the counter and the reload base |
| preset | input | 4 | Start and reload value |
| ext_pin | input | 1 | External event input, asynchronous |
| flag_clr | input | 1 | Clear request for the overflow flag |
| count | output | 4 | Current counter value |
| flag | output | 1 | Sticky overflow flag (interrupt request) |
| pre_ovf | output | 1 | One-cycle prescaler wrap pulse |

## Verification
The assertions assume that `load` is a short strobe. They also assume that `ext_pin` changes only between clock edges, so the synchroniser never resolves metastability in a way that moves an accepted edge by a cycle.

The stimulus drives every input, `ext_pin` included, on the falling clock edge. It uses high and low stretches of 1, 2 or more whole cycles, so the 2-cycle filter boundary is hit exactly. It aligns the load-versus-step and clear-versus-overflow collisions by first observing `pre_ovf`, and `count` = 15, on the falling edge just before the step.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CNT_W = 4;
    localparam int PRE_W_DEF = 6;

    typedef enum logic {
        MODE_TIMER = 1'b0,
        MODE_EVENT = 1'b1
    } tmr_mode_e;

    typedef struct packed {
        logic [CNT_W-1:0] value;
        logic             wrap;
    } step_t;

    // Next counter value for one step; wraps onto the reload base.
    function automatic step_t advance(input logic [CNT_W-1:0] cur,
                                      input logic [CNT_W-1:0] base);
        step_t s;
        if (cur == {CNT_W{1'b1}}) begin
            s.value = base;
            s.wrap  = 1'b1;
        end else begin
            s.value = cur + 1'b1;
            s.wrap  = 1'b0;
        end
        return s;
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PRE_W = tmr_pkg::PRE_W_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic halt,
    output logic wrap_pulse
);
    localparam logic [PRE_W-1:0] TOP = {PRE_W{1'b1}};

    logic [PRE_W-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst)
            phase <= '0;
        else if (!halt)
            phase <= phase + 1'b1;
    end

    assign wrap_pulse = !halt && (phase == TOP);

    // R1
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        wrap_pulse |=> !wrap_pulse);

endmodule

// File: rtl/tmr_edge_qual.sv
module tmr_edge_qual #(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYC    = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise
);
    localparam int HW = $clog2(HOLD_CYC + 1);
    localparam logic [HW-1:0] HLIM = HW'(HOLD_CYC - 1);

    logic [SYNC_STAGES-1:0] chain;
    logic                   settled;
    logic                   level;
    logic [HW-1:0]          held;
    logic                   differ;
    logic                   accept;

    assign settled = chain[SYNC_STAGES-1];
    assign differ  = settled != level;
    assign accept  = differ && (held == HLIM);
    assign rise    = accept && settled;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            level <= 1'b0;
            held  <= '0;
        end else begin
            chain <= {chain[SYNC_STAGES-2:0], pin};
            if (!differ) begin
                held <= '0;
            end else if (accept) begin
                level <= settled;
                held  <= '0;
            end else begin
                held <= held + 1'b1;
            end
        end
    end

    // R7
    rise_single_chk: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

    // R8
    rise_needs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rise |-> $past(settled));

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] preset,
    input  logic             step_en,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    logic [CNT_W-1:0] base;
    step_t            nxt;

    always_comb begin
        nxt  = advance(count, base);
        wrap = step_en && !load && nxt.wrap;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            base  <= '0;
        end else if (load) begin
            count <= preset;
            base  <= preset;
        end else if (step_en) begin
            count <= nxt.value;
        end
    end

    // R3
    load_take_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> count == $past(preset));

    // R5
    wrap_reload_chk: assert property (@(posedge clk) disable iff (rst)
        wrap |=> count == base);

endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (set)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set |=> flag);

    // R6
    clr_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !flag);

endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
    import tmr_pkg::*;
#(
    parameter int PRE_W       = PRE_W_DEF,
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYC    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             halt,
    input  logic             mode,
    input  logic             load,
    input  logic [CNT_W-1:0] preset,
    input  logic             ext_pin,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count,
    output logic             flag,
    output logic             pre_ovf
);
    tmr_mode_e sel;
    logic      ev_rise;
    logic      step_en;
    logic      wrap;

    assign sel = tmr_mode_e'(mode);

    tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk        (clk),
        .rst        (rst),
        .halt       (halt),
        .wrap_pulse (pre_ovf)
    );

    tmr_edge_qual #(.SYNC_STAGES(SYNC_STAGES), .HOLD_CYC(HOLD_CYC)) u_qual (
        .clk  (clk),
        .rst  (rst),
        .pin  (ext_pin),
        .rise (ev_rise)
    );

    always_comb begin
        step_en = 1'b0;
        if (!halt) begin
            case (sel)
                MODE_TIMER: step_en = pre_ovf;
                MODE_EVENT: step_en = ev_rise;
                default:    step_en = 1'b0;
            endcase
        end
    end

    tmr_count_core u_core (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .preset  (preset),
        .step_en (step_en),
        .count   (count),
        .wrap    (wrap)
    );

    tmr_flag u_flag (
        .clk  (clk),
        .rst  (rst),
        .set  (wrap),
        .clr  (flag_clr),
        .flag (flag)
    );

    // R2
    halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (halt && !load) |=> $stable(count));

    // R5
    flag_on_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (wrap && !$past(flag)) |=> $rose(flag));

endmodule

// File: tb/sim_prescaled_timer.sv
module sim_prescaled_timer;

    logic       clk = 1'b0;
    logic       rst, halt, mode, load, ext_pin, flag_clr;
    logic [3:0] preset;
    logic [3:0] count;
    logic       flag, pre_ovf;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    prescaled_timer u0 (
        .clk(clk), .rst(rst), .halt(halt), .mode(mode), .load(load),
        .preset(preset), .ext_pin(ext_pin), .flag_clr(flag_clr),
        .count(count), .flag(flag), .pre_ovf(pre_ovf)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_pulse();
        int g = 0;
        while (!pre_ovf && g < 300) begin
            @(negedge clk);
            g++;
        end
    endtask

    task automatic do_load(input logic [3:0] v);
        preset = v; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic pulse(input int hi, input int lo);
        ext_pin = 1'b1;
        repeat (hi) @(negedge clk);
        ext_pin = 1'b0;
        repeat (lo) @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1; halt = 0; mode = 0; load = 0; ext_pin = 0;
        flag_clr = 0; preset = 4'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R9 count after reset", int'(count), 0);
        chk("R9 flag after reset", int'(flag), 0);
        chk("R9 pre_ovf after reset", int'(pre_ovf), 0);
    endtask

    task automatic t_prescaler();
        int n = 0;
        wait_pulse();
        do begin
            @(negedge clk); n++;
            if (n == 5) load = 1'b1;
            if (n == 6) load = 1'b0;
            if (n == 20) mode = 1'b1;
            if (n == 30) mode = 1'b0;
        end while (!pre_ovf && n < 300);
        chk("R1 prescaler period", n, 64);
    endtask

    task automatic t_halt();
        int n = 0;
        logic [3:0] held = 4'd0;
        int leak = 0;
        mode = 0;
        wait_pulse();
        do begin
            @(negedge clk); n++;
            if (n == 1) begin halt = 1'b1; held = count; end
            else if (n <= 11 && pre_ovf) leak++;
            if (n == 11) begin
                chk("R2 count frozen in halt", int'(count), int'(held));
                halt = 1'b0;
            end
        end while (!(pre_ovf && n > 11) && n < 300);
        chk("R2 no pulse during halt", leak, 0);
        chk("R2 stretched period", n, 74);
    endtask

    task automatic t_load();
        mode = 0;
        wait_pulse();
        do_load(4'd5);
        chk("R3 load beats step", int'(count), 5);
        @(negedge clk);
        do_load(4'd9);
        chk("R3 load value", int'(count), 9);
    endtask

    task automatic t_interval(input int p);
        int n = 0;
        int g = 0;
        mode = 0;
        do_load(4'(p));
        clear_flag();
        while (!flag && g < 3000) begin @(negedge clk); g++; end
        chk($sformatf("R5 reload p=%0d", p), int'(count), p);
        clear_flag();
        n = 1;
        while (!flag && n < 3000) begin @(negedge clk); n++; end
        chk($sformatf("R4 interval p=%0d", p), n, (16 - p) * 64);
    endtask

    task automatic t_set_wins();
        int g = 0;
        mode = 0;
        do_load(4'd14);
        clear_flag();
        chk("R6 flag clear", int'(flag), 0);
        while (!(count == 4'd15 && pre_ovf) && g < 400) begin
            @(negedge clk); g++;
        end
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        chk("R6 set wins over clear", int'(flag), 1);
        chk("R5 reload on wrap", int'(count), 14);
        clear_flag();
        chk("R6 clear alone", int'(flag), 0);
    endtask

    task automatic t_events();
        mode = 1;
        do_load(4'd12);
        clear_flag();
        repeat (3) pulse(3, 3);
        chk("R7 three events", int'(count), 15);
        chk("R7 no flag before wrap", int'(flag), 0);
        repeat (140) @(negedge clk);
        chk("R7 prescaler ignored", int'(count), 15);
        pulse(3, 3);
        chk("R5 event wrap reload", int'(count), 12);
        chk("R5 event wrap flag", int'(flag), 1);
        clear_flag();
    endtask

    task automatic t_latency();
        int n = 0;
        mode = 1;
        do_load(4'd2);
        ext_pin = 1'b1;
        while (count == 4'd2 && n < 10) begin @(negedge clk); n++; end
        chk("R7 step latency", int'(n <= 4), 1);
        chk("R7 latency value", int'(count), 3);
        ext_pin = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_filter();
        mode = 1;
        do_load(4'd3);
        pulse(1, 5);
        chk("R8 short high ignored", int'(count), 3);
        pulse(3, 1);
        pulse(3, 4);
        chk("R8 short gap merges", int'(count), 4);
        pulse(2, 2);
        pulse(2, 4);
        chk("R7 two-cycle levels counted", int'(count), 6);
    endtask

    task automatic t_halt_events();
        mode = 1;
        do_load(4'd7);
        halt = 1'b1;
        pulse(3, 3);
        repeat (3) @(negedge clk);
        halt = 1'b0;
        repeat (4) @(negedge clk);
        chk("R2 events ignored in halt", int'(count), 7);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_prescaler();
        t_halt();
        t_load();
        t_interval(15);
        t_interval(10);
        t_interval(0);
        t_set_wins();
        t_events();
        t_latency();
        t_filter();
        t_halt_events();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule